// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Slice

This block models one logic slice of a programmable fabric. It holds two 4-input lookup cells, called F and G, each with 16 bits of contents, and one storage element after each. Each lookup cell runs in one of three modes. In logic mode it is a fixed truth table. In memory mode it is a 16x1 RAM with a synchronous write and an address-driven read. In shift mode it is a 16-bit shift register whose read tap is chosen by the address. A pairing option joins the two cells into one 32x1 RAM, with the select input acting as the fifth address bit. A combining multiplexer picks F or G under the same select input, which gives any 5-input function.

A two-cell carry chain sits beside the lookup cells. Each cell uses its lookup output as the propagate term. A sum XOR turns each cell into a full-adder bit. A dedicated AND of the two low address bits can stand in for the generate term, for multiplier partial products. Each storage element takes its D input from the slice's combinational output or from a bypass input. Clock enable and two force controls are shared by both elements. One force control sets an element to its configured initial value and the other sets it to the opposite value. Each of the three controls has its own polarity option.

Top module: `lut_slice`

## Requirements
- R1: In logic mode (mode code 00) a cell's output equals bit `addr` of its configured 16-bit contents. `x_out` shows F when `cfg_x_src`=00 and `y_out` shows G when `cfg_y_sum`=0. The output is combinational in the same cycle.
- R2: In memory mode (code 01) a rising edge with `we`=1 writes the cell's data input (`dx` for F, `dy` for G) to the addressed bit. With `we`=0 nothing is written. Reads are combinational by address.
- R3: In shift mode (code 10) each rising edge with clock enable active shifts the contents up by one, and the data input enters bit 0. With enable inactive the contents hold. The address picks the bit that is read.
- R4: With `cfg_x_src`=01, `x_out` shows G when `f5_sel`=1 and F when `f5_sel`=0.
- R5: With `cfg_pair32`=1 and both cells in memory mode, both cells use `f_addr` and take data from `dx`. A write lands in F when `f5_sel`=0 and in G when `f5_sel`=1. Reads come through the combining mux.
- R6: Carry cell i (F is cell 0, G is cell 1) passes the incoming carry when its lookup output is 1 and passes its generate term otherwise. The generate term is `dx` or `dy`. `cfg_x_src`=10 shows F xor `cin`, and `cfg_y_sum`=1 shows G xor the middle carry. `cout` leaves cell 1.
- R7: With `cfg_mul_and`=1 the generate term of each cell is the AND of address bits 0 and 1 of that cell, in place of the bypass input.
- R8: On a rising edge with clock enable active and no force control active, `xq` loads `dx` if `cfg_dsel_x`=1 and `x_out` otherwise. `yq` does the same with `dy` and `y_out`. With enable inactive they hold.
- R9: An active set-to-init control loads `cfg_init_x`/`cfg_init_y` at the next edge, whatever the clock enable. An active set-to-opposite control loads their complements. Set-to-init wins when both are active.
- R10: `cfg_inv_ce`, `cfg_inv_sr` and `cfg_inv_rev` each make the matching control active-low when 1.
- R11: While `rst_n` is low the cells load their configured contents and the storage elements load their initial values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Active-low asynchronous reset, loads configuration |
| cfg_lut_f | input | 16 | Initial contents of cell F |
| cfg_lut_g | input | 16 | Initial contents of cell G |
| cfg_mode_f | input | 2 | Cell F mode: 00 logic, 01 memory, 10 shift |
| cfg_mode_g | input | 2 | Cell G mode, same codes |
| cfg_pair32 | input | 1 | Join both cells into a 32x1 RAM |
| cfg_x_src | input | 2 | x_out source: 00 F, 01 combining mux, 1x sum |
| cfg_y_sum | input | 1 | y_out source: 0 G, 1 sum |
| cfg_mul_and | input | 1 | Generate term from address AND |
| cfg_dsel_x | input | 1 | xq D from dx (1) or x_out (0) |
| cfg_dsel_y | input | 1 | yq D from dy (1) or y_out (0) |
| cfg_init_x | input | 1 | Initial value of xq |
| cfg_init_y | input | 1 | Initial value of yq |
| cfg_inv_ce | input | 1 | Clock enable active-low |
| cfg_inv_sr | input | 1 | Set-to-init control active-low |
| cfg_inv_rev | input | 1 | Set-to-opposite control active-low |
| f_addr | input | 4 | Cell F address |
| g_addr | input | 4 | Cell G address |
| f5_sel | input | 1 | Combining mux select and fifth address bit |
| dx | input | 1 | F bypass, write data, serial input, generate |
| dy | input | 1 | G bypass, write data, serial input, generate |
| we | input | 1 | Memory write enable |
| ce | input | 1 | Clock enable |
| sr | input | 1 | Set-to-init control |
| rev | input | 1 | Set-to-opposite control |
| cin | input | 1 | Carry into cell 0 |
| x_out | output | 1 | Combinational X output |
| y_out | output | 1 | Combinational Y output |
| xq | output | 1 | Registered X |
| yq | output | 1 | Registered Y |
| cout | output | 1 | Carry out of cell 1 |

## Verification
Lookup reads, the combining mux and the carry and sum outputs are combinational. The bench checks them one time step after it sets the inputs, within the same clock period. Memory writes and shifts change the contents at a rising edge, so the bench reads them back by address one time step after that edge. `xq` and `yq` take exactly one edge. The bench drives each setting one step after an edge and compares the result one step after the next edge. The checker compares the storage elements against the controls sampled one edge earlier.

// File: rtl/lut_slice_pkg.sv
package lut_slice_pkg;
    typedef enum logic [1:0] {
        CELL_LOGIC = 2'b00,
        CELL_RAM   = 2'b01,
        CELL_SHIFT = 2'b10
    } cell_mode_e;

    function automatic cell_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return CELL_RAM;
            2'b10:   return CELL_SHIFT;
            default: return CELL_LOGIC;
        endcase
    endfunction
endpackage

// File: rtl/lut_cell.sv
module lut_cell
    import lut_slice_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  init,
    input  cell_mode_e        mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic              shift_en,
    input  logic              din,
    output logic              dout
);
    typedef struct packed {
        logic [DEPTH-1:0] bits;
    } cell_state_t;

    cell_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (mode)
            CELL_RAM: begin
                if (wr_en) st_d.bits[wr_addr] = din;
            end
            CELL_SHIFT: begin
                if (shift_en) st_d.bits = {st_q.bits[DEPTH-2:0], din};
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= init;
        else        st_q <= st_d;
    end

    assign dout = st_q.bits[rd_addr];
endmodule

// File: rtl/slice_carry.sv
module slice_carry #(
    parameter int CELLS = 2
) (
    input  logic [CELLS-1:0] prop,
    input  logic [CELLS-1:0] a0,
    input  logic [CELLS-1:0] a1,
    input  logic [CELLS-1:0] bypass,
    input  logic             mul_and,
    input  logic             cin,
    output logic [CELLS-1:0] sum,
    output logic             cout
);
    logic [CELLS:0] chain;
    assign chain[0] = cin;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        logic gen_t;
        assign gen_t        = mul_and ? (a0[i] & a1[i]) : bypass[i];
        assign chain[i + 1] = prop[i] ? chain[i] : gen_t;
        assign sum[i]       = prop[i] ^ chain[i];
    end

    assign cout = chain[CELLS];
endmodule

// File: rtl/slice_store.sv
module slice_store (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic ce,
    input  logic force_init,
    input  logic force_rev,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic bit_v;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_init)     st_d.bit_v = init;
        else if (force_rev) st_d.bit_v = ~init;
        else if (ce)        st_d.bit_v = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bit_v <= init;
        else        st_q <= st_d;
    end

    assign q = st_q.bit_v;
endmodule

// File: rtl/lut_slice.sv
module lut_slice
    import lut_slice_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W,
    localparam int CELLS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEPTH-1:0]  cfg_lut_f,
    input  logic [DEPTH-1:0]  cfg_lut_g,
    input  logic [1:0]        cfg_mode_f,
    input  logic [1:0]        cfg_mode_g,
    input  logic              cfg_pair32,
    input  logic [1:0]        cfg_x_src,
    input  logic              cfg_y_sum,
    input  logic              cfg_mul_and,
    input  logic              cfg_dsel_x,
    input  logic              cfg_dsel_y,
    input  logic              cfg_init_x,
    input  logic              cfg_init_y,
    input  logic              cfg_inv_ce,
    input  logic              cfg_inv_sr,
    input  logic              cfg_inv_rev,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [ADDR_W-1:0] g_addr,
    input  logic              f5_sel,
    input  logic              dx,
    input  logic              dy,
    input  logic              we,
    input  logic              ce,
    input  logic              sr,
    input  logic              rev,
    input  logic              cin,
    output logic              x_out,
    output logic              y_out,
    output logic              xq,
    output logic              yq,
    output logic              cout
);
    logic ce_eff, sr_eff, rev_eff;
    assign ce_eff  = ce  ^ cfg_inv_ce;
    assign sr_eff  = sr  ^ cfg_inv_sr;
    assign rev_eff = rev ^ cfg_inv_rev;

    logic [CELLS-1:0][DEPTH-1:0]  init_v;
    logic [CELLS-1:0][1:0]        mode_code;
    logic [CELLS-1:0][ADDR_W-1:0] addr_v;
    logic [CELLS-1:0]             din_v, we_v, lut_o, sum_v;
    logic [CELLS-1:0]             a0_v, a1_v, byp_v, d_v, init_q, q_v;
    logic                         f5_out;

    assign init_v    = {cfg_lut_g, cfg_lut_f};
    assign mode_code = {cfg_mode_g, cfg_mode_f};
    assign addr_v[0] = f_addr;
    assign addr_v[1] = cfg_pair32 ? f_addr : g_addr;
    assign din_v[0]  = dx;
    assign din_v[1]  = cfg_pair32 ? dx : dy;
    assign we_v[0]   = we & (~cfg_pair32 | ~f5_sel);
    assign we_v[1]   = we & (~cfg_pair32 |  f5_sel);
    assign byp_v     = {dy, dx};

    for (genvar i = 0; i < CELLS; i++) begin : g_lut
        lut_cell #(.ADDR_W(ADDR_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .init     (init_v[i]),
            .mode     (decode_mode(mode_code[i])),
            .rd_addr  (addr_v[i]),
            .wr_addr  (addr_v[i]),
            .wr_en    (we_v[i]),
            .shift_en (ce_eff),
            .din      (din_v[i]),
            .dout     (lut_o[i])
        );
        assign a0_v[i] = addr_v[i][0];
        assign a1_v[i] = addr_v[i][1];
    end

    slice_carry #(.CELLS(CELLS)) u_carry (
        .prop    (lut_o),
        .a0      (a0_v),
        .a1      (a1_v),
        .bypass  (byp_v),
        .mul_and (cfg_mul_and),
        .cin     (cin),
        .sum     (sum_v),
        .cout    (cout)
    );

    assign f5_out = f5_sel ? lut_o[1] : lut_o[0];

    always_comb begin
        case (cfg_x_src)
            2'b00:   x_out = lut_o[0];
            2'b01:   x_out = f5_out;
            default: x_out = sum_v[0];
        endcase
        y_out = cfg_y_sum ? sum_v[1] : lut_o[1];
    end

    assign d_v[0]   = cfg_dsel_x ? dx : x_out;
    assign d_v[1]   = cfg_dsel_y ? dy : y_out;
    assign init_q   = {cfg_init_y, cfg_init_x};

    for (genvar i = 0; i < CELLS; i++) begin : g_store
        slice_store u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .init       (init_q[i]),
            .ce         (ce_eff),
            .force_init (sr_eff),
            .force_rev  (rev_eff),
            .d          (d_v[i]),
            .q          (q_v[i])
        );
    end

    assign xq = q_v[0];
    assign yq = q_v[1];
endmodule

// File: rtl/lut_slice_checker.sv
module lut_slice_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_inv_ce,
    input logic       cfg_inv_sr,
    input logic       cfg_inv_rev,
    input logic       cfg_init_x,
    input logic       cfg_dsel_x,
    input logic [1:0] cfg_x_src,
    input logic       cfg_y_sum,
    input logic       f5_sel,
    input logic       dx,
    input logic       ce,
    input logic       sr,
    input logic       rev,
    input logic       x_out,
    input logic       y_out,
    input logic       xq
);
    logic ce_a, sr_a, rev_a;
    assign ce_a  = ce  ^ cfg_inv_ce;
    assign sr_a  = sr  ^ cfg_inv_sr;
    assign rev_a = rev ^ cfg_inv_rev;

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_a && !sr_a && !rev_a) |=> $stable(xq));

    a_r8_bypass_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_a && !sr_a && !rev_a && cfg_dsel_x) |=> (xq == $past(dx)));

    a_r9_force_init: assert property (@(posedge clk) disable iff (!rst_n)
        sr_a |=> (xq == $past(cfg_init_x)));

    a_r9_force_opposite: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_a && rev_a) |=> (xq == !$past(cfg_init_x)));

    a_r4_mux_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_x_src == 2'b01 && !cfg_y_sum && f5_sel) |-> (x_out == y_out));
endmodule

bind lut_slice lut_slice_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_inv_ce  (cfg_inv_ce),
    .cfg_inv_sr  (cfg_inv_sr),
    .cfg_inv_rev (cfg_inv_rev),
    .cfg_init_x  (cfg_init_x),
    .cfg_dsel_x  (cfg_dsel_x),
    .cfg_x_src   (cfg_x_src),
    .cfg_y_sum   (cfg_y_sum),
    .f5_sel      (f5_sel),
    .dx          (dx),
    .ce          (ce),
    .sr          (sr),
    .rev         (rev),
    .x_out       (x_out),
    .y_out       (y_out),
    .xq          (xq)
);

// File: tb/sim_lut_slice.sv
module sim_lut_slice;
    localparam time PERIOD = 10;

    logic clk = 0;
    logic rst_n = 0;
    logic [15:0] cfg_lut_f = 0, cfg_lut_g = 0;
    logic [1:0]  cfg_mode_f = 0, cfg_mode_g = 0, cfg_x_src = 0;
    logic cfg_pair32 = 0, cfg_y_sum = 0, cfg_mul_and = 0;
    logic cfg_dsel_x = 0, cfg_dsel_y = 0, cfg_init_x = 0, cfg_init_y = 0;
    logic cfg_inv_ce = 0, cfg_inv_sr = 0, cfg_inv_rev = 0;
    logic [3:0] f_addr = 0, g_addr = 0;
    logic f5_sel = 0, dx = 0, dy = 0, we = 0, ce = 0, sr = 0, rev = 0, cin = 0;
    logic x_out, y_out, xq, yq, cout;

    int checks = 0;
    int errors = 0;

    always #(PERIOD / 2) clk = ~clk;

    lut_slice u0 (.*);

    // {f_addr, g_addr, f5_sel, expected x_out, expected y_out}
    // F = 00FF, G = F0F0, x_out from the combining mux
    localparam logic [10:0] VEC [6] = '{
        {4'd3,  4'd0,  1'b0, 1'b1, 1'b0},
        {4'd9,  4'd5,  1'b0, 1'b0, 1'b1},
        {4'd2,  4'd6,  1'b1, 1'b1, 1'b1},
        {4'd12, 4'd3,  1'b1, 1'b0, 1'b0},
        {4'd7,  4'd15, 1'b0, 1'b1, 1'b1},
        {4'd8,  4'd8,  1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        tick();
        rst_n = 1;
        #1;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset loads contents and initial values
        cfg_lut_f = 16'h00FF; cfg_lut_g = 16'hF0F0;
        cfg_init_x = 1; cfg_init_y = 0;
        do_reset();
        chk("R11 xq init", xq, 1'b1);
        chk("R11 yq init", yq, 1'b0);

        // R1 and R4: table walk
        cfg_x_src = 2'b01;
        foreach (VEC[i]) begin
            {f_addr, g_addr, f5_sel} = VEC[i][10:2];
            #1;
            chk("R4 mux output", x_out, VEC[i][1]);
            chk("R1 G logic read", y_out, VEC[i][0]);
        end
        cfg_x_src = 2'b00; f_addr = 4'd6; #1;
        chk("R1 F logic read", x_out, 1'b1);

        // R6: two-bit adder over all operands
        cfg_lut_f = 16'h6666; cfg_lut_g = 16'h6666;
        do_reset();
        cfg_x_src = 2'b10; cfg_y_sum = 1;
        for (int v = 0; v < 32; v++) begin
            logic [1:0] a, b;
            logic [2:0] s;
            a = v[1:0]; b = v[3:2]; cin = v[4];
            f_addr = {2'b00, b[0], a[0]}; dx = a[0];
            g_addr = {2'b00, b[1], a[1]}; dy = a[1];
            s = a + b + cin;
            #1;
            chk("R6 sum bit0", x_out, s[0]);
            chk("R6 sum bit1", y_out, s[1]);
            chk("R6 carry out", cout, s[2]);
        end

        // R7: AND generate term
        cfg_lut_f = 16'h0000; cfg_lut_g = 16'hFFFF;
        do_reset();
        cfg_mul_and = 1; cin = 0;
        f_addr = 4'b0011; dx = 0; #1;
        chk("R7 and high", cout, 1'b1);
        f_addr = 4'b0010; dx = 1; #1;
        chk("R7 and low", cout, 1'b0);
        cfg_mul_and = 0; #1;
        chk("R7 bypass generate", cout, 1'b1);

        // R2: memory mode
        cfg_lut_f = 16'h0000; cfg_mode_f = 2'b01; cfg_x_src = 2'b00;
        do_reset();
        f_addr = 4'd5; dx = 1; we = 1;
        tick();
        we = 0; #1;
        chk("R2 written bit", x_out, 1'b1);
        f_addr = 4'd4; #1;
        chk("R2 neighbour untouched", x_out, 1'b0);
        dx = 1; we = 0;
        tick();
        chk("R2 no write without we", x_out, 1'b0);

        // R3: shift mode on G
        cfg_lut_g = 16'h0000; cfg_mode_g = 2'b10; cfg_y_sum = 0;
        do_reset();
        ce = 1;
        dy = 1; tick();
        dy = 1; tick();
        dy = 0; tick();
        dy = 1; tick();
        ce = 0;
        g_addr = 4'd0; #1; chk("R3 tap0", y_out, 1'b1);
        g_addr = 4'd1; #1; chk("R3 tap1", y_out, 1'b0);
        g_addr = 4'd2; #1; chk("R3 tap2", y_out, 1'b1);
        g_addr = 4'd3; #1; chk("R3 tap3", y_out, 1'b1);
        g_addr = 4'd4; #1; chk("R3 tap4", y_out, 1'b0);
        dy = 0; tick();
        g_addr = 4'd0; #1; chk("R3 hold without ce", y_out, 1'b1);

        // R5: 32x1 pairing
        cfg_mode_f = 2'b01; cfg_mode_g = 2'b01; cfg_pair32 = 1; cfg_x_src = 2'b01;
        do_reset();
        g_addr = 4'd9;
        we = 1; f_addr = 4'd3; f5_sel = 0; dx = 1; tick();
        f_addr = 4'd7; f5_sel = 1; dx = 1; tick();
        we = 0;
        f_addr = 4'd3; f5_sel = 0; #1; chk("R5 low half written", x_out, 1'b1);
        f5_sel = 1; #1; chk("R5 high half clear", x_out, 1'b0);
        f_addr = 4'd7; #1; chk("R5 high half written", x_out, 1'b1);
        f5_sel = 0; #1; chk("R5 low half clear", x_out, 1'b0);
        cfg_pair32 = 0;

        // R8: capture and hold
        cfg_mode_f = 2'b00; cfg_mode_g = 2'b00; cfg_lut_f = 16'h00FF;
        cfg_x_src = 2'b00; cfg_init_x = 0; cfg_init_y = 0;
        do_reset();
        f_addr = 4'd3; ce = 1; tick();
        chk("R8 capture from x_out", xq, 1'b1);
        f_addr = 4'd9; ce = 0; tick();
        chk("R8 hold", xq, 1'b1);
        ce = 1; tick();
        chk("R8 capture zero", xq, 1'b0);
        cfg_dsel_x = 1; cfg_dsel_y = 1; dx = 1; dy = 1; tick();
        chk("R8 bypass x", xq, 1'b1);
        chk("R8 bypass y", yq, 1'b1);

        // R9: forcing controls
        ce = 0; dx = 0; cfg_init_x = 0; sr = 1; tick();
        chk("R9 force init", xq, 1'b0);
        sr = 0; rev = 1; tick();
        chk("R9 force opposite", xq, 1'b1);
        sr = 1; rev = 1; tick();
        chk("R9 init wins", xq, 1'b0);
        sr = 0; rev = 0;

        // R10: polarity controls
        cfg_inv_ce = 1; ce = 0; dx = 1; tick();
        chk("R10 active-low enable", xq, 1'b1);
        cfg_inv_ce = 0; cfg_inv_sr = 1; sr = 1; cfg_init_x = 0; tick();
        chk("R10 inactive inverted force", xq, 1'b1);
        sr = 0; tick();
        chk("R10 active-low force", xq, 1'b0);
        cfg_inv_sr = 0; sr = 0; cfg_inv_rev = 1; rev = 0; tick();
        chk("R10 active-low opposite", xq, 1'b1);
        cfg_inv_rev = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule